// File: doc/BRIEF.md
# Serial Receive Word Deserializer

This block receives one serial bit in every fast-clock cycle and assembles the bits into J-bit parallel words, with J = 10 by default. A free-running frame counter wraps every J cycles. It produces a one-cycle slow-clock enable and a load strobe. The load strobe copies the shift register into a capture register at one chosen position within the frame, so the alignment phase input moves the recovered word boundary to any of the J bit positions.

Captured words then cross a fixed two-step handoff in the slow domain before they reach the output register. A data-valid flag marks words that are whole and were assembled under a settled phase. The slow clock is represented by the enable, so everything runs from the one fast clock.

Top module: `rx_word_deser`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears its frame counter, shift and word registers. After that edge `word_out` is 0, `word_valid` is 0 and `slow_en` is 0.
- R2: `slow_en` is high for exactly one cycle in every J. It is first high in the J-th cycle after reset is released. The frame position counts 0 in the first cycle after release and reaches J-1 in the `slow_en` cycle.
- R3: One `ser_in` bit is taken per cycle. A captured word holds the J most recent bits, including the bit of the capture cycle, with the oldest bit in bit J-1 and the newest in bit 0.
- R4: A capture happens in the cycle whose frame position equals the effective phase. After reset the effective phase is 2, the third bit slot of the frame.
- R5: `align_phase` is sampled only in `slow_en` cycles and governs the following frame. A value above J-1 acts as J-1.
- R6: A captured word appears on `word_out` at the second `slow_en` edge after the capture. A `slow_en` edge in the capture cycle itself does not count.
- R7: `word_out` and `word_valid` change only at the rising edge that ends a `slow_en` cycle.
- R8: `word_valid` stays 0 over the first two slow updates after reset and becomes 1 at the third.
- R9: When a sampled phase differs from the current one, the second slow update after that sampling edge drives `word_valid` to 0 for one slow period.
- R10: A J-bit pattern P is repeated with its bit J-1 sent at frame position 0. With phase p held, every valid word equals P rotated left by (p+1) mod J.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data, one bit per cycle |
| align_phase | input | $clog2(J) | Requested frame position of the capture strobe |
| slow_en | output | 1 | One-cycle slow-clock enable, once per frame |
| word_out | output | J | Deserialized word, oldest bit in the MSB |
| word_valid | output | 1 | Word is whole and aligned under a settled phase |

## Verification
The hardest condition to reach is a phase change whose capture position lands on the last bit of the frame. There the capture coincides with the slow enable, so the handoff passes a stale copy of the old word instead of a new one. The stimulus sweeps the phase through every value from 0 to J-1 in sequence, which reaches this case and every other pair of adjacent phases. For each step the bench counts the cycles with valid low and checks the rotation of the aligned pattern. A request above J-1 follows the sweep and must cause no valid drop at all.

// File: rtl/rx_deser_pkg.sv
package rx_deser_pkg;

    localparam int DEF_WORD_BITS  = 10;
    localparam int DEF_LOAD_PHASE = 2;
    localparam int FILL_UPDATES   = 2;

    typedef struct packed {
        logic slow_en;
        logic load_en;
        logic phase_chg;
    } frame_ctl_t;

    function automatic int phase_limit(input int req, input int word_bits);
        return (req > word_bits - 1) ? word_bits - 1 : req;
    endfunction

endpackage

// File: rtl/rx_frame_timer.sv
module rx_frame_timer
    import rx_deser_pkg::*;
#(
    parameter int J         = DEF_WORD_BITS,
    parameter int RST_PHASE = DEF_LOAD_PHASE,
    localparam int PW       = $clog2(J)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] phase_req,
    output frame_ctl_t    ctl
);

    localparam logic [PW-1:0] LAST = PW'(J - 1);

    logic [PW-1:0] cnt;
    logic [PW-1:0] phase_q;
    logic [PW-1:0] phase_next;
    logic          at_end;

    assign at_end     = (cnt == LAST);
    assign phase_next = PW'(phase_limit(int'(phase_req), J));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            phase_q <= PW'(RST_PHASE);
        end else begin
            cnt <= at_end ? '0 : cnt + 1'b1;
            if (at_end) begin
                phase_q <= phase_next;
            end
        end
    end

    always_comb begin
        ctl.slow_en   = at_end;
        ctl.load_en   = (cnt == phase_q);
        ctl.phase_chg = at_end && (phase_next != phase_q);
    end

    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        ctl.slow_en |=> (cnt == '0));

    assert_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        ctl.slow_en |=> !ctl.slow_en);

    assert_phase_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !ctl.slow_en |=> $stable(phase_q));

    assert_phase_range_R5: assert property (@(posedge clk) disable iff (rst)
        phase_q <= LAST);

endmodule

// File: rtl/rx_shift_capture.sv
module rx_shift_capture
    import rx_deser_pkg::*;
#(
    parameter int J = DEF_WORD_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ser_in,
    input  logic         load_en,
    output logic [J-1:0] par_word
);

    logic [J-1:0] sh;
    logic [J-1:0] sh_next;

    assign sh_next = {sh[J-2:0], ser_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            par_word <= '0;
        end else begin
            sh <= sh_next;
            if (load_en) begin
                par_word <= sh_next;
            end
        end
    end

    assert_serial_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sh[0] == $past(ser_in)));

    assert_capture_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(par_word));

endmodule

// File: rtl/rx_slow_stage.sv
module rx_slow_stage
    import rx_deser_pkg::*;
#(
    parameter int J = DEF_WORD_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         slow_en,
    input  logic         phase_chg,
    input  logic [J-1:0] par_word,
    output logic [J-1:0] word_out,
    output logic         word_valid
);

    localparam logic [1:0] FILL = 2'(FILL_UPDATES);

    logic [J-1:0] mid;
    logic [1:0]   scnt;
    logic         chg_a;
    logic         chg_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            mid        <= '0;
            word_out   <= '0;
            word_valid <= 1'b0;
            scnt       <= '0;
            chg_a      <= 1'b0;
            chg_b      <= 1'b0;
        end else if (slow_en) begin
            word_out   <= mid;
            mid        <= par_word;
            word_valid <= (scnt == FILL) && !chg_b;
            chg_b      <= chg_a;
            chg_a      <= phase_chg;
            if (scnt != FILL) begin
                scnt <= scnt + 1'b1;
            end
        end
    end

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (word_out == '0) && !word_valid);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !slow_en |=> $stable(word_out) && $stable(word_valid));

    assert_fill_R8: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> (scnt == FILL));

    assert_invalid_R9: assert property (@(posedge clk) disable iff (rst)
        (slow_en && chg_b) |=> !word_valid);

endmodule

// File: rtl/rx_word_deser.sv
module rx_word_deser
    import rx_deser_pkg::*;
#(
    parameter int J         = DEF_WORD_BITS,
    parameter int RST_PHASE = DEF_LOAD_PHASE,
    localparam int PW       = $clog2(J)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ser_in,
    input  logic [PW-1:0] align_phase,
    output logic          slow_en,
    output logic [J-1:0]  word_out,
    output logic          word_valid
);

    frame_ctl_t   ctl;
    logic [J-1:0] cap_word;

    rx_frame_timer #(.J(J), .RST_PHASE(RST_PHASE)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .phase_req (align_phase),
        .ctl       (ctl)
    );

    rx_shift_capture #(.J(J)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .load_en  (ctl.load_en),
        .par_word (cap_word)
    );

    rx_slow_stage #(.J(J)) u_slow (
        .clk        (clk),
        .rst        (rst),
        .slow_en    (ctl.slow_en),
        .phase_chg  (ctl.phase_chg),
        .par_word   (cap_word),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

    assign slow_en = ctl.slow_en;

endmodule

// File: tb/rx_word_deser_bench.sv
module rx_word_deser_bench;

    localparam int J  = 10;
    localparam int PW = $clog2(J);
    localparam logic [J-1:0] PAT = 10'b1101001100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ser_in = 1'b0;
    logic [PW-1:0] align_phase = PW'(2);
    logic          slow_en;
    logic [J-1:0]  word_out;
    logic          word_valid;

    int compared = 0;
    int mismatched = 0;

    always #2 clk = ~clk;

    rx_word_deser #(.J(J)) u_rx_word_deser (
        .clk         (clk),
        .rst         (rst),
        .ser_in      (ser_in),
        .align_phase (align_phase),
        .slow_en     (slow_en),
        .word_out    (word_out),
        .word_valid  (word_valid)
    );

    // behavioural reference
    bit           hist[$];
    int           m_pos;
    int           m_phase;
    int           m_upd;
    bit           m_chg_new, m_chg_old;
    logic [J-1:0] m_cap, m_mid, m_out;
    logic         m_valid;

    function automatic logic [J-1:0] recent_word();
        logic [J-1:0] w = '0;
        for (int k = 0; k < J; k++) begin
            if (hist.size() - 1 - k >= 0) w[k] = hist[hist.size() - 1 - k];
        end
        return w;
    endfunction

    function automatic logic [J-1:0] rotl(input logic [J-1:0] p, input int s);
        logic [J-1:0] r;
        for (int i = 0; i < J; i++) r[J-1-i] = p[J-1-((i + s) % J)];
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            hist.delete();
            m_pos = 0; m_phase = 2; m_upd = 0;
            m_chg_new = 0; m_chg_old = 0;
            m_cap = '0; m_mid = '0; m_out = '0; m_valid = 0;
        end else begin
            int req;
            logic [J-1:0] cap_next;
            req = (int'(align_phase) > J - 1) ? J - 1 : int'(align_phase);
            hist.push_back(ser_in);
            if (hist.size() > J) void'(hist.pop_front());
            cap_next = (m_pos == m_phase) ? recent_word() : m_cap;
            if (m_pos == J - 1) begin
                m_out     = m_mid;
                m_mid     = m_cap;
                m_valid   = (m_upd >= 2) && !m_chg_old;
                m_chg_old = m_chg_new;
                m_chg_new = (req != m_phase);
                m_phase   = req;
                if (m_upd < 2) m_upd++;
            end
            m_cap = cap_next;
            m_pos = (m_pos == J - 1) ? 0 : m_pos + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // stimulus
    bit         pat_mode = 1;
    int         dpos = 0;
    logic [15:0] lfsr = 16'hACE1;
    int         low_count = 0;

    task automatic drive_bit();
        if (pat_mode) begin
            ser_in = PAT[J-1-dpos];
            dpos = (dpos + 1) % J;
        end else begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ser_in = lfsr[0];
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) begin
            @(negedge clk);
            check("R2 slow_en", 32'(slow_en), 32'(m_pos == J - 1));
            check("R8/R9 word_valid", 32'(word_valid), 32'(m_valid));
            check("R3/R4/R6 word_out", 32'(word_out), 32'(m_out));
            if (!word_valid) low_count++;
            drive_bit();
        end
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst = 1'b0;
        dpos = 0;
        drive_bit();
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 word_out in reset", 32'(word_out), 32'h0);
        check("R1 word_valid in reset", 32'(word_valid), 32'h0);
        check("R1 slow_en in reset", 32'(slow_en), 32'h0);

        // fill and default capture position
        release_reset();
        cyc(3 * J - 1);
        check("R8 valid low before third update", 32'(word_valid), 32'h0);
        cyc(1);
        check("R8 valid at third update", 32'(word_valid), 32'h1);
        cyc(2 * J);
        check("R4 default phase word", 32'(word_out), 32'(rotl(PAT, 3)));

        // sweep every phase
        for (int p = 0; p < J; p++) begin
            align_phase = PW'(p);
            low_count = 0;
            cyc(6 * J);
            check("R9 one invalid slow period per change", low_count, J);
            check("R10 valid after settle", 32'(word_valid), 32'h1);
            check("R10 rotated pattern", 32'(word_out), 32'(rotl(PAT, (p + 1) % J)));
        end

        // out-of-range request behaves as J-1, which is already in force
        align_phase = PW'(15);
        low_count = 0;
        cyc(6 * J);
        check("R5 saturated request causes no change", low_count, 0);
        check("R5 saturated request word", 32'(word_out), 32'(PAT));

        // pseudo-random data with phase moves
        pat_mode = 0;
        align_phase = PW'(5);
        cyc(20 * J);
        align_phase = PW'(0);
        cyc(10 * J);

        // reset mid-run with a different requested phase
        @(negedge clk);
        rst = 1'b1;
        align_phase = PW'(7);
        cyc(2);
        check("R1 word_out after re-reset", 32'(word_out), 32'h0);
        pat_mode = 1;
        release_reset();
        cyc(8 * J);
        check("R10 phase 7 after reset", 32'(word_out), 32'(rotl(PAT, 8)));

        report();
        $finish;
    end

endmodule